// File: doc/BRIEF.md
# Bus-Hold Block Transfer Controller

This block moves a block of bytes between memory and a single peripheral while the processor keeps running. Software writes a direction, a first memory address and an item count through a small register port. The block is then armed. When the peripheral raises its service request, the controller asks the processor for the system bus. It waits for the grant, tells the peripheral it has been selected, and runs one strobed bus cycle per item.

In each item cycle the data passes directly between memory and the peripheral on the shared data bus. The controller drives only the address and a matched pair of strobes: one for memory and one for the peripheral. After each item the address goes up by one and the count goes down by one. When the count runs out, the controller hands the bus back and raises an interrupt. The interrupt stays raised until software clears it. The block can pause without losing its place in two cases: when the processor takes the grant away, and when the peripheral withdraws its request.

Top module: `bus_hold_dma`

## Requirements
- R1: Register selects: 0 = direction (bit 0: 0 moves memory to peripheral, 1 moves peripheral to memory); 1 = current memory address; 2 = remaining count; 3 = status. On read, status bit 0 is the interrupt flag and bit 1 is the armed flag. Selects 0 to 2 read back their current values.
- R2: Writing a nonzero count arms the block. Writing zero leaves it unarmed. While armed and idle, a high `devReq` raises `holdReq` one clock later. While unarmed, `devReq` is ignored.
- R3: `devAck`, the strobes and a nonzero `busAddr` appear only after `holdAck` has been sampled high. `holdReq` stays high for as long as `devAck` is high.
- R4: Each item lasts SETUP_CLKS + STROBE_CLKS + RELEASE_CLKS clocks and drives the current address on `busAddr`. The strobes are active for exactly STROBE_CLKS clocks in the middle of the item. Direction 0 uses `memRd` with `ioWr`; direction 1 uses `ioRd` with `memWr`. No other strobe is ever active.
- R5: After each item the address increments, wrapping modulo 2^ADDR_W, and the count decrements. Items are issued at consecutive addresses from the programmed start.
- R6: When the last item ends, `holdReq` falls and `irq` rises on the same clock edge, and the armed flag clears.
- R7: `irq` stays high until a write to select 3 with bit 0 set.
- R8: After completion, a request from the peripheral is ignored until a nonzero count is written again.
- R9: If `holdAck` is low at the end of an item, the controller finishes that item, keeps `holdReq` high and drops `devAck`. Once the grant returns, it resumes with the address and count it had kept.
- R10: If `devReq` is low at the end of an item that is not the last, the controller drops `holdReq` and goes idle. It stays armed with the remaining count, and resumes when `devReq` returns.
- R11: Writes to selects 0 to 2 are ignored while `holdReq` is high.
- R12: After reset, all outputs are low, and the status, address and count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data (combinational on regSel) |
| devReq | input | 1 | Peripheral service request |
| devAck | output | 1 | Peripheral selected for the current transfer |
| holdReq | output | 1 | Bus request to the processor |
| holdAck | input | 1 | Bus grant from the processor |
| busAddr | output | ADDR_W | Memory address, zero when not owning the bus |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | Peripheral read strobe |
| ioWr | output | 1 | Peripheral write strobe |
| irq | output | 1 | Completion interrupt |

## Verification
Transfers are run with random direction, start address, length and grant latency. This separates correct address stepping and strobe pairing from errors that only show up at particular lengths or directions. Directed runs cover a start address just below the top of the address space (wrap), a single-item block, and a zero count. They also cover a grant withdrawn mid-block, which must pause the transfer while keeping the bus request, and a request withdrawn mid-block, which must release the bus but stay armed. One run writes configuration registers while the bus is held, so an accepted write would show up as a wrong address or item count.

// File: rtl/bhdma_pkg.sv
package bhdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ownBus;    // address phase through release
    logic strobeOn;  // strobe phase
    logic advance;   // last clock of an item
    logic finish;    // last clock of the last item
    logic cfgOpen;   // configuration writes accepted
  } dmaCtl_t;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_ADDR   = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

endpackage

// File: rtl/bhdma_datapath.sv
module bhdma_datapath
  import bhdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  dmaCtl_t           ctl,
  output logic              armed,
  output logic              lastItem,
  output logic              dirMode,
  output logic              irqFlag,
  output logic [ADDR_W-1:0] busAddr
);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  cnt;
  logic              cfgWrite;
  logic              clrIrq;

  assign cfgWrite = regWr && ctl.cfgOpen;
  assign clrIrq   = regWr && (regSel == SEL_STATUS) && regWdata[0];
  assign lastItem = (cnt == CNT_W'(1));
  assign busAddr  = ctl.ownBus ? curAddr : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirMode <= 1'b0;
      curAddr <= '0;
      cnt     <= '0;
      armed   <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (ctl.advance) begin
        curAddr <= curAddr + 1'b1;
        cnt     <= cnt - 1'b1;
      end
      if (ctl.finish) begin
        armed   <= 1'b0;
        irqFlag <= 1'b1;
      end else if (clrIrq) begin
        irqFlag <= 1'b0;
      end
      if (cfgWrite) begin
        case (regSel)
          SEL_MODE:  dirMode <= regWdata[0];
          SEL_ADDR:  curAddr <= regWdata[ADDR_W-1:0];
          SEL_COUNT: begin
            cnt   <= regWdata[CNT_W-1:0];
            armed <= |regWdata[CNT_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_MODE:  regRdata = REG_W'(dirMode);
      SEL_ADDR:  regRdata = REG_W'(curAddr);
      SEL_COUNT: regRdata = REG_W'(cnt);
      default:   regRdata = REG_W'({armed, irqFlag});
    endcase
  end

  // R5: address and count step once per finished item
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)) &&
                    (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R7: interrupt holds until cleared
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrIrq) |=> irqFlag);

  // R2: a zero count never arms
  p_zero_no_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && regSel == SEL_COUNT && regWdata[CNT_W-1:0] == '0) |=> !armed);

  // R8: armed always has work left
  p_armed_has_work_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (cnt != '0));

endmodule

// File: rtl/bhdma_control.sv
module bhdma_control
  import bhdma_pkg::*;
#(
  parameter int SETUP_CLKS   = 1,
  parameter int STROBE_CLKS  = 2,
  parameter int RELEASE_CLKS = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    devReq,
  input  logic    holdAck,
  input  logic    armed,
  input  logic    lastItem,
  input  logic    dirMode,
  output logic    holdReq,
  output logic    devAck,
  output logic    memRd,
  output logic    memWr,
  output logic    ioRd,
  output logic    ioWr,
  output dmaCtl_t ctl
);

  localparam int MAX_AB = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
  localparam int MAX_PH = (MAX_AB > RELEASE_CLKS) ? MAX_AB : RELEASE_CLKS;
  localparam int PH_W   = $clog2(MAX_PH + 1);

  dmaState_e       state, stateNxt;
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLen;
  logic            phaseEnd;
  logic            ownBus;

  assign ownBus = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RELEASE);

  always_comb begin
    case (state)
      ST_SETUP:   phaseLen = PH_W'(SETUP_CLKS);
      ST_STROBE:  phaseLen = PH_W'(STROBE_CLKS);
      ST_RELEASE: phaseLen = PH_W'(RELEASE_CLKS);
      default:    phaseLen = PH_W'(1);
    endcase
  end

  assign phaseEnd = (phaseCnt == phaseLen - PH_W'(1));

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:    if (armed && devReq) stateNxt = ST_REQ;
      ST_REQ:     if (holdAck) stateNxt = ST_SETUP;
      ST_SETUP:   if (phaseEnd) stateNxt = ST_STROBE;
      ST_STROBE:  if (phaseEnd) stateNxt = ST_RELEASE;
      ST_RELEASE: if (phaseEnd) begin
        if (lastItem)      stateNxt = ST_IDLE;
        else if (!holdAck) stateNxt = ST_REQ;
        else if (!devReq)  stateNxt = ST_IDLE;
        else               stateNxt = ST_SETUP;
      end
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state <= stateNxt;
      if (!ownBus || phaseEnd) phaseCnt <= '0;
      else                     phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.ownBus   = ownBus;
    ctl.strobeOn = (state == ST_STROBE);
    ctl.advance  = (state == ST_RELEASE) && phaseEnd;
    ctl.finish   = (state == ST_RELEASE) && phaseEnd && lastItem;
    ctl.cfgOpen  = (state == ST_IDLE);
  end

  assign holdReq = (state != ST_IDLE);
  assign devAck  = ownBus;
  assign memRd   = ctl.strobeOn && !dirMode;
  assign ioWr    = ctl.strobeOn && !dirMode;
  assign ioRd    = ctl.strobeOn && dirMode;
  assign memWr   = ctl.strobeOn && dirMode;

  // R3: peripheral selected only after a sampled grant
  p_ack_after_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devAck) |-> $past(holdAck));

  // R3: bus request spans the whole ownership
  p_hold_spans_r3: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> holdReq);

  // R4: strobes only while owning the bus, never both directions
  p_strobe_inside_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || ioRd || ioWr) |-> devAck);
  p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr}) && $onehot0({ioRd, ioWr}));

  // R9: lost grant keeps the request but leaves the bus
  p_keep_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !lastItem && !holdAck) |=> (holdReq && !devAck));

endmodule

// File: rtl/bus_hold_dma.sv
module bus_hold_dma
  import bhdma_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 16,
  parameter int REG_W        = 16,
  parameter int SETUP_CLKS   = 1,
  parameter int STROBE_CLKS  = 2,
  parameter int RELEASE_CLKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              devReq,
  output logic              devAck,
  output logic              holdReq,
  input  logic              holdAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic              irq
);

  dmaCtl_t ctl;
  logic    armed;
  logic    lastItem;
  logic    dirMode;

  bhdma_control #(
    .SETUP_CLKS  (SETUP_CLKS),
    .STROBE_CLKS (STROBE_CLKS),
    .RELEASE_CLKS(RELEASE_CLKS)
  ) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .devReq  (devReq),
    .holdAck (holdAck),
    .armed   (armed),
    .lastItem(lastItem),
    .dirMode (dirMode),
    .holdReq (holdReq),
    .devAck  (devAck),
    .memRd   (memRd),
    .memWr   (memWr),
    .ioRd    (ioRd),
    .ioWr    (ioWr),
    .ctl     (ctl)
  );

  bhdma_datapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .REG_W (REG_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .regSel  (regSel),
    .regWr   (regWr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .ctl     (ctl),
    .armed   (armed),
    .lastItem(lastItem),
    .dirMode (dirMode),
    .irqFlag (irq),
    .busAddr (busAddr)
  );

  // R6: interrupt appears with the bus already returned
  p_irq_free_bus_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> !holdReq);

endmodule

// File: tb/sim_bus_hold_dma.sv
`timescale 1ns/1ps
module sim_bus_hold_dma;
  localparam int ADDR_W = 16;
  localparam int STROBE = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        devReq = 1'b0;
  logic        devAck;
  logic        holdReq;
  logic        holdAck = 1'b0;
  logic [15:0] busAddr;
  logic        memRd, memWr, ioRd, ioWr, irq;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  // monitor state
  int  seenItems = 0, addrBad = 0, widthBad = 0, protoBad = 0, width = 0;
  bit  prevPair = 0;
  bit  curDir = 0;
  logic [15:0] curStart = '0;
  // processor model
  int grantLat = 0, waitCnt = 0;
  bit blockGrant = 0;

  always #2 clk = ~clk;

  bus_hold_dma u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .devReq(devReq), .devAck(devAck), .holdReq(holdReq),
    .holdAck(holdAck), .busAddr(busAddr), .memRd(memRd), .memWr(memWr),
    .ioRd(ioRd), .ioWr(ioWr), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // processor grants the bus after grantLat clocks
  always @(negedge clk) begin
    if (!rstN || !holdReq || blockGrant) begin
      holdAck = 1'b0;
      waitCnt = 0;
    end else if (!holdAck) begin
      if (waitCnt >= grantLat) holdAck = 1'b1;
      else waitCnt++;
    end
  end

  // bus monitor
  always @(negedge clk) begin
    bit pairNow, wrong;
    pairNow = curDir ? (ioRd && memWr) : (memRd && ioWr);
    wrong   = curDir ? (memRd || ioWr) : (ioRd || memWr);
    if (rstN) begin
      if (wrong) protoBad++;
      if ((memRd || memWr || ioRd || ioWr) && !devAck) protoBad++;
      if (devAck && !holdReq) protoBad++;
      if (pairNow && !prevPair) begin
        if (busAddr != 16'(curStart + 16'(seenItems))) addrBad++;
        seenItems++;
        width = 1;
      end else if (pairNow) begin
        width++;
      end
      if (!pairNow && prevPair && width != STROBE) widthBad++;
      prevPair = pairNow;
    end
  end

  task automatic writeReg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    regSel = s; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    regSel = s;
    #1 v = regRdata;
  endtask

  // mode 0 plain, 1 grant withdrawn, 2 request withdrawn, 3 writes while busy
  task automatic runXfer(input bit dir, input logic [15:0] start, input int n, input int mode);
    logic [15:0] v;
    bit did = 0;
    writeReg(2'd0, {15'd0, dir});
    writeReg(2'd1, start);
    writeReg(2'd2, 16'(n));
    readReg(2'd0, v); chk(v == {15'd0, dir}, "R1 mode readback", v, dir);
    readReg(2'd1, v); chk(v == start, "R1 address readback", v, start);
    readReg(2'd2, v); chk(v == 16'(n), "R1 count readback", v, n);
    seenItems = 0; addrBad = 0; widthBad = 0; protoBad = 0; prevPair = 0;
    curDir = dir; curStart = start;
    devReq = 1'b1;
    @(negedge clk); #1;
    chk(holdReq == 1'b1, "R2 request one clock after devReq", holdReq, 1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (irq) break;
      if (mode == 1 && !did && seenItems == 3) begin
        blockGrant = 1; holdAck = 1'b0;
        repeat (30) @(negedge clk);
        #1;
        chk(seenItems == 3, "R9 paused after current item", seenItems, 3);
        chk(holdReq && !devAck, "R9 request kept, bus left", {holdReq, devAck}, 2);
        blockGrant = 0; did = 1;
      end
      if (mode == 2 && !did && seenItems == 2) begin
        devReq = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        chk(holdReq == 1'b0, "R10 bus released", holdReq, 0);
        readReg(2'd3, v); chk(v[1] == 1'b1, "R10 still armed", v, 2);
        readReg(2'd2, v); chk(v == 16'(n - 2), "R10 remaining count", v, n - 2);
        devReq = 1'b1; did = 1;
      end
      if (mode == 3 && !did && seenItems == 1) begin
        writeReg(2'd1, 16'h1234);
        writeReg(2'd2, 16'd77);
        writeReg(2'd0, {15'd0, ~dir});
        did = 1;
      end
    end
    chk(irq == 1'b1, "R6 interrupt raised", irq, 1);
    chk(holdReq == 1'b0, "R6 bus returned at interrupt", holdReq, 0);
    chk(seenItems == n, "R5 item count", seenItems, n);
    chk(addrBad == 0 && widthBad == 0 && protoBad == 0, "R4 address, strobe width and pairing",
        addrBad + widthBad + protoBad, 0);
    readReg(2'd1, v); chk(v == 16'(start + 16'(n)), "R5 final address", v, 16'(start + 16'(n)));
    readReg(2'd2, v); chk(v == 16'd0, "R5 final count", v, 0);
    readReg(2'd3, v); chk(v == 16'd1, "R6 armed cleared, irq set", v, 1);
    if (mode == 3) begin
      readReg(2'd0, v); chk(v == {15'd0, dir}, "R11 mode unchanged", v, dir);
    end
    // request kept high: no restart without a new count
    repeat (20) @(negedge clk);
    #1;
    chk(holdReq == 1'b0, "R8 no restart after completion", holdReq, 0);
    chk(irq == 1'b1, "R7 interrupt held", irq, 1);
    devReq = 1'b0;
    writeReg(2'd3, 16'd1);
    #1 chk(irq == 1'b0, "R7 interrupt cleared", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    #1;
    chk({holdReq, devAck, memRd, memWr, ioRd, ioWr, irq} == 7'd0, "R12 outputs low",
        {holdReq, devAck, memRd, memWr, ioRd, ioWr, irq}, 0);
    rstN = 1'b1;
    readReg(2'd3, v); chk(v == 16'd0, "R12 status zero", v, 0);
    readReg(2'd1, v); chk(v == 16'd0, "R12 address zero", v, 0);
    chk(busAddr == 16'd0, "R12 bus address zero", busAddr, 0);

    // unarmed request and zero count
    devReq = 1'b1;
    repeat (10) @(negedge clk);
    #1 chk(holdReq == 1'b0, "R2 unarmed request ignored", holdReq, 0);
    devReq = 1'b0;
    writeReg(2'd2, 16'd0);
    devReq = 1'b1;
    repeat (10) @(negedge clk);
    #1 chk(holdReq == 1'b0, "R2 zero count does not arm", holdReq, 0);
    devReq = 1'b0;

    // directed corners
    grantLat = 2;
    runXfer(1'b0, 16'hFFFE, 4, 0);   // R5 address wrap
    runXfer(1'b1, 16'h0040, 1, 0);   // single item
    grantLat = 1;
    runXfer(1'b0, 16'h0100, 8, 1);   // R9
    runXfer(1'b1, 16'h0200, 6, 2);   // R10
    runXfer(1'b0, 16'h0300, 5, 3);   // R11

    // random transfers
    for (int k = 0; k < 12; k++) begin
      grantLat = int'($urandom_range(0, 4));
      runXfer(1'($urandom_range(0, 1)), 16'($urandom), int'($urandom_range(1, 12)), 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule